// File: doc/BRIEF.md
# Colour-Keyed Bounding-Box Tracker

This block sits in a raster pixel stream and looks for objects of one programmable colour. Each pixel arrives with its own column and row coordinates and a valid strobe. A pixel whose three channels all lie inside a programmable window is a key hit. The block gathers the extent of the hits for up to two separate objects. It then outlines each object with a black rectangle on the following frame. The hit pixels themselves are repainted pure red, so the object stands out from the background.

A frame-start pulse closes the frame being gathered. At that pulse the finished boxes are latched as the boxes drawn during the new frame, and gathering restarts. A small state machine follows the progress through a frame. `ST_IDLE` holds after reset until the first frame start. `ST_SEEK` means no hit has been seen yet in the current frame. `ST_ONE` means object one has been seeded. `ST_TWO` means object two has been seeded as well. The transitions are these:
- `ST_IDLE`→`ST_SEEK` on a frame start.
- `ST_SEEK`→`ST_ONE` on the first hit.
- `ST_ONE`→`ST_TWO` on a hit that lies beyond the gap around object one.
- Any state →`ST_SEEK` on every frame start.

With motion mode on, the doubled centre of object one is compared between the frame that just ended and the frame before it. Four flags report the direction, and a dead-band keeps small jitter from showing as motion.

Top module: `colour_box_tracker`

## Requirements
- R1: During and after reset, `out_vld` and all four direction flags are 0. No rectangle is drawn during the first frame after reset.
- R2: A pixel is a key hit when `detect_en` is 1 and every channel lies inside its window. The window is inclusive at both ends. Red is bits 23:16 of `key_lo` and `key_hi`, green is bits 15:8, and blue is bits 7:0. A hit pixel that lies on no drawn rectangle is output as (255,0,0).
- R3: Every valid input pixel gives exactly one valid output pixel, one clock cycle later, in the same order. A pixel that is neither a hit nor on a rectangle passes through unchanged.
- R4: The first hit of a frame seeds object one: its top and bottom are set to the row of that hit, and its left and right are set to the column of that hit. Later hits assigned to object one lower its left bound to the smallest column seen, raise its right bound to the largest column seen, and raise its bottom bound to the largest row seen.
- R5: The boxes gathered in a frame are drawn during the next frame. A pixel whose column lies in [left,right] while its row equals top or bottom is output as (0,0,0). A pixel whose row lies in [top,bottom] while its column equals left or right is also output as (0,0,0). Black takes priority over red.
- R6: After object one exists, a hit goes to object two when its column plus `gap` is below object one's left bound. It also goes to object two when its column exceeds right plus `gap`, or when its row exceeds bottom plus `gap`. Any other hit extends object one. Object two grows by the same rules as object one, and both boxes are drawn.
- R7: When `detect_en` is 0, no pixel is repainted red and no box is gathered. The next frame therefore draws no rectangle.
- R8: At each frame start, the direction flags are updated and then held until the next frame start. The update uses dx, the change in (left+right) of object one, and dy, the change in (top+bottom) of object one. `dir_right` is dx > 2·DEAD_BAND and `dir_left` is dx < −2·DEAD_BAND. `dir_down` is dy > 2·DEAD_BAND and `dir_up` is dy < −2·DEAD_BAND. All flags are 0 when `motion_en` is 0, or when either frame lacks object one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that closes a frame; no pixel is gathered in this cycle |
| pix_vld | input | 1 | Input pixel valid |
| pix_x | input | 10 | Pixel column |
| pix_y | input | 9 | Pixel row |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| detect_en | input | 1 | Enables hit detection |
| motion_en | input | 1 | Enables direction reporting, sampled at frame start |
| key_lo | input | 24 | Lower bounds of the colour window {r,g,b} |
| key_hi | input | 24 | Upper bounds of the colour window {r,g,b} |
| gap | input | 6 | Separation beyond object one that starts object two |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |
| dir_left | output | 1 | Object one moved left |
| dir_right | output | 1 | Object one moved right |
| dir_up | output | 1 | Object one moved up |
| dir_down | output | 1 | Object one moved down |

## Verification
A wrong bound or a wrong object assignment stays hidden during the frame in which it is made. It shows one frame later as black pixels in the wrong place, or as missing black pixels, so the bench compares every pixel of the following frame. A stuck or wrongly seeded state shows the same way, as a missing or shifted outline. A wrong centre or dead-band shows on the direction flags in the cycle right after the next frame start. The test frames therefore place motion just inside and just outside the dead-band on both axes.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int unsigned XW = 10;
    localparam int unsigned YW = 9;
    localparam int unsigned CW = 8;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [XW-1:0] l;
        logic [XW-1:0] r;
        logic [YW-1:0] t;
        logic [YW-1:0] b;
    } box_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_ONE  = 2'd2,
        ST_TWO  = 2'd3
    } scan_e;
endpackage

// File: rtl/cbt_key_match.sv
module cbt_key_match
    import cbt_pkg::*;
(
    input  rgb_t pix,
    input  rgb_t lo,
    input  rgb_t hi,
    input  logic en,
    output logic hit
);
    localparam int unsigned NCH = 3;

    logic [NCH-1:0][CW-1:0] pv, lv, hv;
    logic [NCH-1:0]         ok;

    assign pv = {pix.r, pix.g, pix.b};
    assign lv = {lo.r, lo.g, lo.b};
    assign hv = {hi.r, hi.g, hi.b};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign ok[c] = (pv[c] >= lv[c]) && (pv[c] <= hv[c]);
        end
    endgenerate

    assign hit = en & (&ok);
endmodule

// File: rtl/cbt_box_tracker.sv
module cbt_box_tracker
    import cbt_pkg::*;
#(
    parameter int unsigned GAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_vld,
    input  logic             hit,
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    input  logic [GAP_W-1:0] gap,
    output box_t [1:0]       disp_box,
    output logic [1:0]       disp_vld,
    output box_t             cur_box1,
    output logic             cur_vld1
);
    localparam int unsigned XE = XW + 1;
    localparam int unsigned YE = YW + 1;

    scan_e st, st_nx;
    box_t  box1, box2;
    logic  take, far;

    logic [XE-1:0] xe, gx, l1e, r1e;
    logic [YE-1:0] ye, gy, b1e;

    assign take = pix_vld && hit && !frame_start;

    assign xe  = XE'(x);
    assign gx  = XE'(gap);
    assign l1e = XE'(box1.l);
    assign r1e = XE'(box1.r);
    assign ye  = YE'(y);
    assign gy  = YE'(gap);
    assign b1e = YE'(box1.b);

    // beyond the gap on the left, right or below object one
    assign far = ((xe + gx) < l1e) || (xe > (r1e + gx)) || (ye > (b1e + gy));

    function automatic box_t seed(input logic [XW-1:0] px, input logic [YW-1:0] py);
        box_t s;
        s.l = px;
        s.r = px;
        s.t = py;
        s.b = py;
        return s;
    endfunction

    function automatic box_t grow(input box_t bx, input logic [XW-1:0] px,
                                  input logic [YW-1:0] py);
        box_t g;
        g = bx;
        if (px < bx.l) g.l = px;
        if (px > bx.r) g.r = px;
        if (py > bx.b) g.b = py;
        return g;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (frame_start) begin
            st_nx = ST_SEEK;
        end else begin
            unique case (st)
                ST_IDLE: st_nx = ST_IDLE;
                ST_SEEK: if (take) st_nx = ST_ONE;
                ST_ONE:  if (take && far) st_nx = ST_TWO;
                ST_TWO:  st_nx = ST_TWO;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // box registers and display capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            box1     <= '0;
            box2     <= '0;
            disp_box <= '0;
            disp_vld <= '0;
        end else if (frame_start) begin
            disp_box[0] <= box1;
            disp_box[1] <= box2;
            disp_vld[0] <= (st == ST_ONE) || (st == ST_TWO);
            disp_vld[1] <= (st == ST_TWO);
        end else if (take) begin
            unique case (st)
                ST_SEEK: box1 <= seed(x, y);
                ST_ONE: begin
                    if (far) box2 <= seed(x, y);
                    else     box1 <= grow(box1, x, y);
                end
                ST_TWO: begin
                    if (far) box2 <= grow(box2, x, y);
                    else     box1 <= grow(box1, x, y);
                end
                default: ;
            endcase
        end
    end

    assign cur_box1 = box1;
    assign cur_vld1 = (st == ST_ONE) || (st == ST_TWO);

    // R4: the first hit of a frame seeds object one at its own coordinates
    p_first_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEEK && take) |=> (st == ST_ONE && box1.t == $past(y) &&
                                     box1.l == $past(x) && box1.r == $past(x)));

    // R4: an active box never has inverted bounds
    p_box_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ONE || st == ST_TWO) |-> (box1.l <= box1.r && box1.t <= box1.b));

    // R6: object two is drawn only alongside object one
    p_two_needs_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> disp_vld[0]);

    // R5: a frame start always reopens gathering
    p_fs_reseek_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st == ST_SEEK));
endmodule

// File: rtl/cbt_overlay.sv
module cbt_overlay
    import cbt_pkg::*;
#(
    parameter int unsigned N_OBJ = 2
) (
    input  rgb_t                  pix,
    input  logic                  hit,
    input  logic [XW-1:0]         x,
    input  logic [YW-1:0]         y,
    input  box_t [N_OBJ-1:0]      box,
    input  logic [N_OBJ-1:0]      vld,
    output rgb_t                  out
);
    logic [N_OBJ-1:0] on_line;

    generate
        for (genvar o = 0; o < N_OBJ; o++) begin : g_obj
            logic in_x, in_y, on_v, on_h;
            assign in_x = (x >= box[o].l) && (x <= box[o].r);
            assign in_y = (y >= box[o].t) && (y <= box[o].b);
            assign on_v = ((x == box[o].l) || (x == box[o].r)) && in_y;
            assign on_h = ((y == box[o].t) || (y == box[o].b)) && in_x;
            assign on_line[o] = vld[o] && (on_v || on_h);
        end
    endgenerate

    always_comb begin
        if (|on_line) begin
            out = '0;
        end else if (hit) begin
            out.r = {CW{1'b1}};
            out.g = '0;
            out.b = '0;
        end else begin
            out = pix;
        end
    end
endmodule

// File: rtl/cbt_motion.sv
module cbt_motion
    import cbt_pkg::*;
#(
    parameter int unsigned DEAD_BAND = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic motion_en,
    input  box_t new_box,
    input  logic new_vld,
    input  box_t old_box,
    input  logic old_vld,
    output logic dir_left,
    output logic dir_right,
    output logic dir_up,
    output logic dir_down
);
    localparam int unsigned SXW = XW + 1;
    localparam int unsigned SYW = YW + 1;
    localparam int unsigned LIM = 2 * DEAD_BAND;
    localparam logic signed [SXW:0] LIMX = (SXW+1)'(LIM);
    localparam logic signed [SYW:0] LIMY = (SYW+1)'(LIM);

    logic [SXW-1:0]        nsx, osx;
    logic [SYW-1:0]        nsy, osy;
    logic signed [SXW:0]   dx;
    logic signed [SYW:0]   dy;

    assign nsx = SXW'(new_box.l) + SXW'(new_box.r);
    assign osx = SXW'(old_box.l) + SXW'(old_box.r);
    assign nsy = SYW'(new_box.t) + SYW'(new_box.b);
    assign osy = SYW'(old_box.t) + SYW'(old_box.b);
    assign dx  = $signed({1'b0, nsx}) - $signed({1'b0, osx});
    assign dy  = $signed({1'b0, nsy}) - $signed({1'b0, osy});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_left  <= 1'b0;
            dir_right <= 1'b0;
            dir_up    <= 1'b0;
            dir_down  <= 1'b0;
        end else if (frame_start) begin
            if (motion_en && new_vld && old_vld) begin
                dir_right <= dx > LIMX;
                dir_left  <= dx < -LIMX;
                dir_down  <= dy > LIMY;
                dir_up    <= dy < -LIMY;
            end else begin
                dir_left  <= 1'b0;
                dir_right <= 1'b0;
                dir_up    <= 1'b0;
                dir_down  <= 1'b0;
            end
        end
    end

    // R8: opposite directions are never reported together
    p_lr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dir_left, dir_right}));
    p_ud_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dir_up, dir_down}));

    // R8: flags hold between frame starts
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable({dir_left, dir_right, dir_up, dir_down}));

    // R8: motion mode off clears every flag
    p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !motion_en) |=> !(dir_left | dir_right | dir_up | dir_down));
endmodule

// File: rtl/colour_box_tracker.sv
module colour_box_tracker
    import cbt_pkg::*;
#(
    parameter int unsigned GAP_W     = 6,
    parameter int unsigned DEAD_BAND = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_vld,
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    input  logic [CW-1:0]     pix_r,
    input  logic [CW-1:0]     pix_g,
    input  logic [CW-1:0]     pix_b,
    input  logic              detect_en,
    input  logic              motion_en,
    input  logic [3*CW-1:0]   key_lo,
    input  logic [3*CW-1:0]   key_hi,
    input  logic [GAP_W-1:0]  gap,
    output logic              out_vld,
    output logic [CW-1:0]     out_r,
    output logic [CW-1:0]     out_g,
    output logic [CW-1:0]     out_b,
    output logic              dir_left,
    output logic              dir_right,
    output logic              dir_up,
    output logic              dir_down
);
    localparam int unsigned N_OBJ = 2;

    rgb_t             pix_c, lo_c, hi_c, ov_pix, out_q;
    logic             hit;
    box_t [N_OBJ-1:0] disp_box;
    logic [N_OBJ-1:0] disp_vld;
    box_t             cur_box1;
    logic             cur_vld1;

    assign pix_c = {pix_r, pix_g, pix_b};
    assign lo_c  = key_lo;
    assign hi_c  = key_hi;

    cbt_key_match u_match (
        .pix (pix_c),
        .lo  (lo_c),
        .hi  (hi_c),
        .en  (detect_en),
        .hit (hit)
    );

    cbt_box_tracker #(.GAP_W(GAP_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_vld     (pix_vld),
        .hit         (hit),
        .x           (pix_x),
        .y           (pix_y),
        .gap         (gap),
        .disp_box    (disp_box),
        .disp_vld    (disp_vld),
        .cur_box1    (cur_box1),
        .cur_vld1    (cur_vld1)
    );

    cbt_overlay #(.N_OBJ(N_OBJ)) u_ovl (
        .pix (pix_c),
        .hit (hit),
        .x   (pix_x),
        .y   (pix_y),
        .box (disp_box),
        .vld (disp_vld),
        .out (ov_pix)
    );

    cbt_motion #(.DEAD_BAND(DEAD_BAND)) u_motion (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .motion_en   (motion_en),
        .new_box     (cur_box1),
        .new_vld     (cur_vld1),
        .old_box     (disp_box[0]),
        .old_vld     (disp_vld[0]),
        .dir_left    (dir_left),
        .dir_right   (dir_right),
        .dir_up      (dir_up),
        .dir_down    (dir_down)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else begin
            out_vld <= pix_vld;
            out_q   <= ov_pix;
        end
    end

    assign out_r = out_q.r;
    assign out_g = out_q.g;
    assign out_b = out_q.b;

    // R3: one output pixel per input pixel, one cycle later
    p_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);
    p_no_extra_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !out_vld);
endmodule

// File: tb/colour_box_tracker_tb_top.sv
module colour_box_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_vld = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  pix_y = '0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        detect_en = 1'b1;
    logic        motion_en = 1'b1;
    logic [23:0] key_lo = {8'd200, 8'd0, 8'd0};
    logic [23:0] key_hi = {8'd255, 8'd60, 8'd60};
    logic [5:0]  gap = 6'd4;
    logic        out_vld;
    logic [7:0]  out_r, out_g, out_b;
    logic        dir_left, dir_right, dir_up, dir_down;

    always #5 clk = ~clk;

    colour_box_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_vld(pix_vld),
        .pix_x(pix_x), .pix_y(pix_y), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .detect_en(detect_en), .motion_en(motion_en), .key_lo(key_lo), .key_hi(key_hi),
        .gap(gap), .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .dir_left(dir_left), .dir_right(dir_right), .dir_up(dir_up), .dir_down(dir_down)
    );

    typedef struct { int l; int r; int t; int b; } rb_t;
    typedef struct { int r; int g; int b; string tag; } exp_t;

    localparam int FW = 32;
    localparam int FH = 24;

    exp_t  sb[$];
    exp_t  e;
    int    n_chk = 0, n_fail = 0;
    rb_t   cur[3];
    int    n_cur = 0;
    rb_t   disp[2], pend[2];
    bit    dvld[2] = '{0, 0};
    bit    pvld[2] = '{0, 0};
    bit    det_now = 1'b1;
    string line_tag = "R5";
    bit    done = 1'b0;

    function automatic rb_t mk(int l, int r, int t, int b);
        rb_t q;
        q.l = l; q.r = r; q.t = t; q.b = b;
        return q;
    endfunction

    function automatic bit key_hit(int r, int g, int b);
        return (r >= 200) && (r <= 255) && (g <= 60) && (b <= 60);
    endfunction

    function automatic bit in_rect(rb_t q, int x, int y);
        return x >= q.l && x <= q.r && y >= q.t && y <= q.b;
    endfunction

    function automatic bit on_outline(rb_t q, int x, int y);
        return ((x == q.l || x == q.r) && y >= q.t && y <= q.b) ||
               ((y == q.t || y == q.b) && x >= q.l && x <= q.r);
    endfunction

    // driver: one frame of pixels, expected results pushed to the scoreboard
    task automatic send_frame();
        for (int y = 0; y < FH; y++) begin
            for (int x = 0; x < FW; x++) begin
                int r, g, b;
                bit obj, ln;
                exp_t ex;
                obj = 1'b0;
                for (int k = 0; k < n_cur; k++) if (in_rect(cur[k], x, y)) obj = 1'b1;
                if (obj) begin
                    r = (x % 2 == 1) ? 255 : 200; g = 60; b = 0;
                end else if (x == 0 && y == 0) begin
                    r = 199; g = 10; b = 10;
                end else if (x == FW-1 && y == 0) begin
                    r = 255; g = 61; b = 0;
                end else begin
                    r = (x * 7) % 256; g = 90 + y; b = y * 5;
                end
                ln = 1'b0;
                for (int k = 0; k < 2; k++) if (dvld[k] && on_outline(disp[k], x, y)) ln = 1'b1;
                if (ln) begin
                    ex.r = 0; ex.g = 0; ex.b = 0; ex.tag = line_tag;
                end else if (det_now && key_hit(r, g, b)) begin
                    ex.r = 255; ex.g = 0; ex.b = 0; ex.tag = "R2";
                end else begin
                    ex.r = r; ex.g = g; ex.b = b;
                    ex.tag = (obj && !det_now) ? "R7" : "R3";
                end
                @(posedge clk); #1;
                pix_vld = 1'b1;
                pix_x = 10'(x); pix_y = 9'(y);
                pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
                sb.push_back(ex);
            end
        end
        @(posedge clk); #1;
        pix_vld = 1'b0;
    endtask

    // frame start pulse, direction check, expected display update
    task automatic new_frame(bit el, bit er, bit eu, bit ed, string tag);
        @(posedge clk); #1;
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
        n_chk++;
        if ({dir_left, dir_right, dir_up, dir_down} != {el, er, eu, ed}) begin
            n_fail++;
            $display("FAIL %s direction flags LRUD actual=%b expected=%b", tag,
                     {dir_left, dir_right, dir_up, dir_down}, {el, er, eu, ed});
        end
        disp = pend;
        dvld = pvld;
        pvld = '{0, 0};
    endtask

    // monitor: compare each output pixel against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected output pixel actual=%0d,%0d,%0d expected=none",
                         out_r, out_g, out_b);
            end else begin
                e = sb.pop_front();
                if (out_r != 8'(e.r) || out_g != 8'(e.g) || out_b != 8'(e.b)) begin
                    n_fail++;
                    $display("FAIL %s pixel at %0d,%0d actual=%0d,%0d,%0d expected=%0d,%0d,%0d",
                             e.tag, pix_x, pix_y, out_r, out_g, out_b, e.r, e.g, e.b);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (out_vld !== 1'b0 || {dir_left, dir_right, dir_up, dir_down} !== 4'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00000",
                     out_vld, {dir_left, dir_right, dir_up, dir_down});
        end
        @(posedge clk); #1;
        rst_n = 1'b1;

        // F0: first frame, nothing drawn yet (R1)
        new_frame(0, 0, 0, 0, "R1");
        cur[0] = mk(4, 9, 3, 7); n_cur = 1;
        pend[0] = mk(4, 9, 3, 7); pvld = '{1, 0};
        line_tag = "R1";
        send_frame();

        // F1: previous object one did not exist -> no motion (R8)
        new_frame(0, 0, 0, 0, "R8");
        cur[0] = mk(8, 13, 3, 7); cur[1] = mk(22, 27, 14, 18); n_cur = 2;
        pend[0] = mk(8, 13, 3, 7); pend[1] = mk(22, 27, 14, 18); pvld = '{1, 1};
        line_tag = "R5";
        send_frame();

        // F2: moved right by 8 doubled units (R8); patch inside the gap extends object one (R6)
        new_frame(0, 1, 0, 0, "R8");
        cur[0] = mk(8, 13, 6, 10); cur[1] = mk(16, 16, 6, 7); cur[2] = mk(22, 27, 14, 18);
        n_cur = 3;
        pend[0] = mk(8, 16, 6, 10); pend[1] = mk(22, 27, 14, 18); pvld = '{1, 1};
        line_tag = "R4";
        send_frame();

        // F3: dx=3 inside the dead-band, dy=6 down (R8); detection off (R7)
        new_frame(0, 0, 0, 1, "R8");
        det_now = 1'b0; detect_en = 1'b0;
        cur[0] = mk(1, 4, 1, 3); n_cur = 1;
        pvld = '{0, 0};
        line_tag = "R6";
        send_frame();

        // F4: no object in F3 -> no outline drawn (R7), flags clear
        new_frame(0, 0, 0, 0, "R7");
        det_now = 1'b1; detect_en = 1'b1;
        cur[0] = mk(10, 14, 2, 5); n_cur = 1;
        pend[0] = mk(10, 14, 2, 5); pvld = '{1, 0};
        send_frame();

        // F5: old display invalid -> flags clear (R8)
        new_frame(0, 0, 0, 0, "R8");
        cur[0] = mk(2, 6, 0, 1); n_cur = 1;
        pend[0] = mk(2, 6, 0, 1); pvld = '{1, 0};
        line_tag = "R5";
        send_frame();

        // F6: moved left and up (R8); motion mode then turned off
        new_frame(1, 0, 1, 0, "R8");
        motion_en = 1'b0;
        pend[0] = mk(2, 6, 0, 1); pvld = '{1, 0};
        send_frame();

        // F7 start: motion off clears flags (R8)
        new_frame(0, 0, 0, 0, "R8");
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R3 missing output pixels actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule